// File: doc/BRIEF.md
# Supervisor Timer Compare Interrupt Unit

This unit produces two level-sensitive timer interrupt pending bits for a hart: one for the supervisor and one for a virtualized guest supervisor. It holds a supervisor compare register, a guest compare register and a guest time offset. Each cycle it compares the free-running time value against the supervisor compare register. It also compares the time value plus the guest offset, wrapped to the counter width, against the guest compare register. Both comparisons are unsigned.

A pending bit is set for as long as its time is at or past its compare value. It clears once software moves the compare value ahead of that time. Each bit is gated by enables. The supervisor bit needs the machine-level counter enable. The guest bit needs three things: a hypervisor-present strap, the machine-level enable and the hypervisor-level enable. Software writes full-width values through one shared data port, and each register has its own write strobe. Both outputs are registered.

Top module: `stimer_compare_unit`

## Requirements
- R1: `stip_o` is 1 when `time_i` >= the supervisor compare value, treated as unsigned numbers, and `m_cnt_en` is 1. Otherwise it is 0.
- R2: `vstip_o` is 1 when ((`time_i` + guest offset) mod 2^TIME_W) >= the guest compare value, unsigned, and all guest enables are 1. Otherwise it is 0.
- R3: Both bits are levels. A bit drops once its compare value is rewritten above its current (offset) time.
- R4: With a compare value of all ones, the bit is 1 only while the (offset) time is all ones. It returns to 0 when time wraps to zero.
- R5: `stip_o` is forced to 0 while `m_cnt_en` is 0.
- R6: `vstip_o` is forced to 0 unless `hyp_present`, `m_cnt_en` and `h_cnt_en` are all 1.
- R7: A synchronous active-high `rst` clears both compare registers, the guest offset and both outputs. With the enables set, time at zero and nothing written after reset, both bits read 1.
- R8: Writing a compare value at or below the current (offset) time raises its bit with time held constant.
- R9: A change on `time_i` or an enable appears on the outputs after the next rising edge. A register write appears on the outputs one edge after the edge that stores it.
- R10: `st_cmp_we`, `vs_cmp_we` and `vs_delta_we` each load the full `wr_data` in one cycle into their own register only. The other registers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | TIME_W | Free-running time value |
| wr_data | input | TIME_W | Write data shared by all registers |
| st_cmp_we | input | 1 | Load supervisor compare register |
| vs_cmp_we | input | 1 | Load guest compare register |
| vs_delta_we | input | 1 | Load guest time offset |
| m_cnt_en | input | 1 | Machine-level compare enable |
| h_cnt_en | input | 1 | Hypervisor-level compare enable |
| hyp_present | input | 1 | Strap: hypervisor extension present |
| stip_o | output | 1 | Supervisor timer pending |
| vstip_o | output | 1 | Guest supervisor timer pending |

## Verification
A change on time or on an enable is due at the outputs after one rising edge. A register write is due after two edges: one to store the value and one to register the new comparison. The bench drives inputs at the falling edge and steps exactly that many rising edges before it samples, again at a falling edge. For timing, it also checks that an output has not yet moved before its due edge. The sweeps use an 8-bit counter so that every time value is covered for each compare and offset setting.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum int {
    SEL_ST_CMP = 0,
    SEL_VS_CMP = 1,
    SEL_VS_DLY = 2
  } stc_sel_e;
  localparam int STC_NUM_REGS = 3;
endpackage

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/stc_pend.sv
module stc_pend #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] now,
  input  logic [W-1:0] cmp,
  input  logic         gate,
  output logic         hit,
  output logic         pend
);
  function automatic logic reached(input logic [W-1:0] t, input logic [W-1:0] c);
    return t >= c;
  endfunction

  assign hit = reached(now, cmp);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= hit & gate;
  end
endmodule

// File: rtl/stimer_compare_unit.sv
module stimer_compare_unit
  import stc_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] wr_data,
  input  logic              st_cmp_we,
  input  logic              vs_cmp_we,
  input  logic              vs_delta_we,
  input  logic              m_cnt_en,
  input  logic              h_cnt_en,
  input  logic              hyp_present,
  output logic              stip_o,
  output logic              vstip_o
);
  localparam int NCH = 2;

  function automatic logic [TIME_W-1:0] guest_time(input logic [TIME_W-1:0] t,
                                                   input logic [TIME_W-1:0] d);
    return t + d;
  endfunction

  logic [STC_NUM_REGS-1:0] reg_we;
  logic [TIME_W-1:0]       reg_q [STC_NUM_REGS];

  assign reg_we[SEL_ST_CMP] = st_cmp_we;
  assign reg_we[SEL_VS_CMP] = vs_cmp_we;
  assign reg_we[SEL_VS_DLY] = vs_delta_we;

  for (genvar i = 0; i < STC_NUM_REGS; i++) begin : g_reg
    stc_cmp_reg #(.W(TIME_W)) u_reg (
      .clk (clk),
      .rst (rst),
      .we  (reg_we[i]),
      .d   (wr_data),
      .q   (reg_q[i])
    );
  end

  logic [TIME_W-1:0] st_cmp_q, vs_cmp_q, vs_delta_q, vs_now;
  logic              st_gate, vs_gate, st_hit, vs_hit;

  assign st_cmp_q   = reg_q[SEL_ST_CMP];
  assign vs_cmp_q   = reg_q[SEL_VS_CMP];
  assign vs_delta_q = reg_q[SEL_VS_DLY];
  assign vs_now     = guest_time(time_i, vs_delta_q);
  assign st_gate    = m_cnt_en;
  assign vs_gate    = hyp_present & m_cnt_en & h_cnt_en;

  logic [TIME_W-1:0] ch_now  [NCH];
  logic [TIME_W-1:0] ch_cmp  [NCH];
  logic [NCH-1:0]    ch_gate, ch_hit, ch_pend;

  assign ch_now[0]  = time_i;
  assign ch_cmp[0]  = st_cmp_q;
  assign ch_gate[0] = st_gate;
  assign ch_now[1]  = vs_now;
  assign ch_cmp[1]  = vs_cmp_q;
  assign ch_gate[1] = vs_gate;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    stc_pend #(.W(TIME_W)) u_pend (
      .clk  (clk),
      .rst  (rst),
      .now  (ch_now[c]),
      .cmp  (ch_cmp[c]),
      .gate (ch_gate[c]),
      .hit  (ch_hit[c]),
      .pend (ch_pend[c])
    );
  end

  assign st_hit  = ch_hit[0];
  assign vs_hit  = ch_hit[1];
  assign stip_o  = ch_pend[0];
  assign vstip_o = ch_pend[1];
endmodule

// File: rtl/stimer_compare_unit_chk.sv
module stimer_compare_unit_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [TIME_W-1:0] time_i,
  input logic [TIME_W-1:0] wr_data,
  input logic              st_cmp_we,
  input logic              vs_delta_we,
  input logic              m_cnt_en,
  input logic              h_cnt_en,
  input logic              hyp_present,
  input logic              stip_o,
  input logic              vstip_o,
  input logic [TIME_W-1:0] st_cmp_q,
  input logic [TIME_W-1:0] vs_cmp_q,
  input logic [TIME_W-1:0] vs_delta_q
);
  logic [TIME_W-1:0] off_time;
  assign off_time = time_i + vs_delta_q;

  // R1
  st_level_set_chk: assert property (@(posedge clk) disable iff (rst)
    (m_cnt_en && time_i >= st_cmp_q) |=> stip_o);
  // R3
  st_level_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (time_i < st_cmp_q) |=> !stip_o);
  // R2
  vs_level_chk: assert property (@(posedge clk) disable iff (rst)
    (hyp_present && m_cnt_en && h_cnt_en && off_time >= vs_cmp_q) |=> vstip_o);
  // R5
  st_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !m_cnt_en |=> !stip_o);
  // R6
  vs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(hyp_present && m_cnt_en && h_cnt_en) |=> !vstip_o);
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!stip_o && !vstip_o && st_cmp_q == '0 && vs_delta_q == '0));
  // R10
  st_write_chk: assert property (@(posedge clk) disable iff (rst)
    st_cmp_we |=> st_cmp_q == $past(wr_data));
  // R10
  delta_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vs_delta_we |=> $stable(vs_delta_q));
endmodule

bind stimer_compare_unit stimer_compare_unit_chk #(.TIME_W(TIME_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .time_i      (time_i),
  .wr_data     (wr_data),
  .st_cmp_we   (st_cmp_we),
  .vs_delta_we (vs_delta_we),
  .m_cnt_en    (m_cnt_en),
  .h_cnt_en    (h_cnt_en),
  .hyp_present (hyp_present),
  .stip_o      (stip_o),
  .vstip_o     (vstip_o),
  .st_cmp_q    (st_cmp_q),
  .vs_cmp_q    (vs_cmp_q),
  .vs_delta_q  (vs_delta_q)
);

// File: tb/stimer_compare_unit_bench.sv
module stimer_compare_unit_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] time_i, wr_data;
  logic         st_cmp_we, vs_cmp_we, vs_delta_we;
  logic         m_cnt_en, h_cnt_en, hyp_present;
  logic         stip_o, vstip_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stimer_compare_unit #(.TIME_W(W)) u_stimer_compare_unit (
    .clk(clk), .rst(rst), .time_i(time_i), .wr_data(wr_data),
    .st_cmp_we(st_cmp_we), .vs_cmp_we(vs_cmp_we), .vs_delta_we(vs_delta_we),
    .m_cnt_en(m_cnt_en), .h_cnt_en(h_cnt_en), .hyp_present(hyp_present),
    .stip_o(stip_o), .vstip_o(vstip_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sel: 0 supervisor compare, 1 guest compare, 2 guest offset
  task automatic wr(input int sel, input int v);
    wr_data     = v[W-1:0];
    st_cmp_we   = (sel == 0);
    vs_cmp_we   = (sel == 1);
    vs_delta_we = (sel == 2);
    tick();
    st_cmp_we = 1'b0; vs_cmp_we = 1'b0; vs_delta_we = 1'b0;
    tick();
  endtask

  int st_tab [12] = '{0, 1, 17, 60, 127, 128, 200, 254, 255, 5, 99, 180};
  int dl_tab [12] = '{0, 1, 100, 255, 128, 3, 50, 200, 0, 77, 254, 16};
  int vc_tab [12] = '{0, 255, 10, 128, 1, 254, 90, 0, 255, 60, 200, 33};

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; time_i = '0; wr_data = '0;
    st_cmp_we = 1'b0; vs_cmp_we = 1'b0; vs_delta_we = 1'b0;
    m_cnt_en = 1'b1; h_cnt_en = 1'b1; hyp_present = 1'b1;
    @(negedge clk);
    tick(); tick();
    check("R7 stip in reset", stip_o, 1'b0);
    check("R7 vstip in reset", vstip_o, 1'b0);
    rst = 1'b0;
    tick();
    check("R7 stip after reset cmp=0", stip_o, 1'b1);
    check("R7 vstip after reset cmp=0 delta=0", vstip_o, 1'b1);

    // R1 R2 sweeps over all time values
    for (int i = 0; i < 12; i++) begin
      wr(0, st_tab[i]);
      wr(1, vc_tab[i]);
      wr(2, dl_tab[i]);
      for (int t = 0; t < 256; t++) begin
        time_i = t[W-1:0];
        tick();
        check("R1 stip sweep", stip_o, t >= st_tab[i]);
        check("R2 vstip sweep", vstip_o, ((t + dl_tab[i]) % 256) >= vc_tab[i]);
      end
    end

    // R4 all-ones compare
    wr(2, 0);
    wr(0, 255); wr(1, 255);
    time_i = 8'd254; tick();
    check("R4 stip t=254", stip_o, 1'b0);
    time_i = 8'd255; tick();
    check("R4 stip t=255", stip_o, 1'b1);
    check("R4 vstip t=255", vstip_o, 1'b1);
    time_i = 8'd0; tick();
    check("R4 stip wrap", stip_o, 1'b0);
    check("R4 vstip wrap", vstip_o, 1'b0);

    // R8 and R3 with time held
    time_i = 8'd50; wr(0, 100); wr(1, 100);
    check("R8 stip before", stip_o, 1'b0);
    wr(0, 40);
    check("R8 stip past write", stip_o, 1'b1);
    wr(1, 50);
    check("R8 vstip equal write", vstip_o, 1'b1);
    wr(0, 60);
    check("R3 stip drop", stip_o, 1'b0);
    wr(1, 51);
    check("R3 vstip drop", vstip_o, 1'b0);

    // R9 timing
    wr(0, 100); time_i = 8'd99; tick();
    check("R9 stip pre", stip_o, 1'b0);
    time_i = 8'd100; #1;
    check("R9 stip not before edge", stip_o, 1'b0);
    tick();
    check("R9 stip after one edge", stip_o, 1'b1);
    wr_data = 8'd200; st_cmp_we = 1'b1; tick(); st_cmp_we = 1'b0;
    check("R9 stip holds on store edge", stip_o, 1'b1);
    tick();
    check("R9 stip after write", stip_o, 1'b0);

    // R5 R6 gating, all combinations
    wr(0, 0); wr(1, 0); wr(2, 0);
    for (int e = 0; e < 8; e++) begin
      hyp_present = e[0]; m_cnt_en = e[1]; h_cnt_en = e[2];
      tick();
      check("R5 stip gate", stip_o, e[1]);
      check("R6 vstip gate", vstip_o, e[0] & e[1] & e[2]);
    end
    hyp_present = 1'b1; m_cnt_en = 1'b1; h_cnt_en = 1'b1;

    // R10 isolation
    time_i = 8'd150; wr(0, 100); wr(1, 200); wr(2, 0);
    check("R10 base stip", stip_o, 1'b1);
    check("R10 base vstip", vstip_o, 1'b0);
    wr(2, 60);
    check("R10 offset write vstip", vstip_o, 1'b1);
    check("R10 offset write leaves stip", stip_o, 1'b1);
    wr(1, 220);
    check("R10 guest cmp write", vstip_o, 1'b0);
    check("R10 guest cmp leaves stip", stip_o, 1'b1);
    wr(0, 151);
    check("R10 st cmp write", stip_o, 1'b0);
    time_i = 8'd160; tick();
    check("R10 st cmp leaves guest", vstip_o, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule